// File: doc/BRIEF.md
# NOR flash command sequencer

This block turns a single host request into the bus-cycle sequence a parallel NOR flash expects for its single-word commands. It covers identification entry, return to array read, array read after an unlock, single-word program, block erase, chip erase and the query-mode entry. The host drives an opcode, a target address and a data word, then pulses `start` for one cycle. The sequencer then works through the steps of that command on an asynchronous memory port. Each step has a chip enable, an address, write data, and a write or output-enable strobe. When the last step has finished, the sequencer pulses `done`.

The host side is plain control, not a valid/ready stream. A request is taken only while `busy` is low. A `start` that arrives while a command is in flight is not queued: it is answered with a one-cycle `reject` pulse, and the running command carries on unchanged. Commands that end in a read cycle (identification, array read, query) return the sampled word on `rdata`, which is valid from the cycle in which `done` is high. Command addresses are word offsets. They are doubled when `cfg_wide` selects a 16-bit device. The host address is always placed on the bus as given.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, and `busy`, `done`, `error` and `reject` are low.
- R2: Opcodes 0, 2, 3, 4 and 5 begin with two unlock writes: first 0xAA at command offset 0x555, then 0x55 at command offset 0x2AA.
- R3: Opcode 0 (identification) writes 0x90 at offset 0x555 after the unlock. It then performs one read cycle at the host address, and that word appears on `rdata` while `done` is high.
- R4: Opcode 1 (return to read) is exactly one write of 0xF0 at bus address 0.
- R5: Opcode 2 (array read) writes 0xF0 at offset 0x555 after the unlock. It then performs one read cycle at the host address and returns the word on `rdata`.
- R6: Opcode 3 (program) writes 0xA0 at offset 0x555 after the unlock. It then writes the host data word at the host address.
- R7: Opcodes 4 (block erase) and 5 (chip erase) run six writes. After the unlock come 0x80 at 0x555, 0xAA at 0x555 and 0x55 at 0x2AA. The sixth write is 0x30 at the host address for opcode 4, or 0x10 at offset 0x555 for opcode 5.
- R8: Opcode 6 (query) has no unlock. It writes 0x98 at offset 0x55, then performs one read cycle at the host address and returns the word on `rdata`.
- R9: With `cfg_wide`=1 a command offset is shifted left by one bit to form the bus address. With `cfg_wide`=0 it is used unchanged. Host addresses are never shifted.
- R10: Each step holds `mem_ce_n` low with a stable address and data. The strobe stays high for `cfg_setup` cycles, is low for `cfg_strobe` cycles, then a single hold cycle follows. A count of zero acts as one. `mem_we_n` and `mem_oe_n` are never low together, and neither is low while `mem_ce_n` is high.
- R11: A `start` seen while `busy` is high gives a `reject` pulse in the next cycle. It adds no bus cycle and does not alter the running sequence.
- R12: Opcode 7 is invalid. It gives `done` and `error` together in the cycle after `start` and produces no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1: 16-bit device, command offsets doubled |
| cfg_setup | input | CNT_W | Setup cycles before the strobe (0 acts as 1) |
| cfg_strobe | input | CNT_W | Strobe-low cycles (0 acts as 1) |
| start | input | 1 | One-cycle request strobe |
| opcode | input | 3 | Command code (0..6 valid, 7 invalid) |
| addr | input | ADDR_W | Host address (block, program or read target) |
| wdata | input | DATA_W | Program data word |
| busy | output | 1 | A command is in flight |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | With `done`: opcode was invalid |
| reject | output | 1 | One-cycle pulse: request refused while busy |
| rdata | output | DATA_W | Word sampled by the last read cycle |
| mem_addr | output | ADDR_W | Flash address bus |
| mem_wdata | output | DATA_W | Flash write data |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_rdata | input | DATA_W | Flash read data |

## Verification
The scoreboard records every strobe on the flash port against an ordered list of expected items. A wrong unlock offset, an erase that drops a step, or a query that gains an unlock prefix therefore shows up as a mismatch or as an unexpected bus cycle. The bench runs both bus widths, because a design that shifts host addresses, or that forgets to shift command offsets, puts the wrong address on the 16-bit or the 8-bit run. Setup and strobe lengths are measured with zero, small and asymmetric counts; a design that treats zero as zero cycles, or that swaps the two counts, gives the wrong widths. A request made in the middle of a program command, and an invalid opcode, must leave the bus silent. A design that queued the request or started cycles for opcode 7 would emit extra bus cycles the scoreboard did not expect.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam int OFFSET_W = 12;
  localparam int CODE_W   = 8;

  localparam logic [2:0] OP_IDENT  = 3'd0;
  localparam logic [2:0] OP_RESET  = 3'd1;
  localparam logic [2:0] OP_READ   = 3'd2;
  localparam logic [2:0] OP_PROG   = 3'd3;
  localparam logic [2:0] OP_BERASE = 3'd4;
  localparam logic [2:0] OP_CERASE = 3'd5;
  localparam logic [2:0] OP_QUERY  = 3'd6;

  typedef enum logic [1:0] {
    SK_END = 2'd0,
    SK_WR  = 2'd1,
    SK_RD  = 2'd2
  } step_kind_e;

  typedef struct packed {
    step_kind_e          kind;
    logic                host_addr;  // use the host address instead of a command offset
    logic                host_data;  // use the host data word instead of a command code
    logic [OFFSET_W-1:0] offset;
    logic [CODE_W-1:0]   code;
  } step_t;

  function automatic step_t mk_step(step_kind_e k, logic ha, logic hd,
                                    logic [OFFSET_W-1:0] off, logic [CODE_W-1:0] c);
    step_t s;
    s.kind      = k;
    s.host_addr = ha;
    s.host_data = hd;
    s.offset    = off;
    s.code      = c;
    return s;
  endfunction

  function automatic logic op_is_valid(logic [2:0] op);
    return op != 3'd7;
  endfunction

endpackage

// File: rtl/nor_step_rom.sv
module nor_step_rom
  import nor_seq_pkg::*;
(
  input  logic [2:0] op,
  input  logic [2:0] idx,
  output step_t      step
);

  logic [2:0] tail;  // index past the unlock prefix

  always_comb begin
    tail = idx - 3'd2;
    step = mk_step(SK_END, 1'b0, 1'b0, 12'h000, 8'h00);
    case (op)
      OP_RESET: begin
        if (idx == 3'd0) step = mk_step(SK_WR, 1'b0, 1'b0, 12'h000, 8'hF0);
      end
      OP_QUERY: begin
        if (idx == 3'd0)      step = mk_step(SK_WR, 1'b0, 1'b0, 12'h055, 8'h98);
        else if (idx == 3'd1) step = mk_step(SK_RD, 1'b1, 1'b0, 12'h000, 8'h00);
      end
      OP_IDENT, OP_READ, OP_PROG, OP_BERASE, OP_CERASE: begin
        if (idx == 3'd0)      step = mk_step(SK_WR, 1'b0, 1'b0, 12'h555, 8'hAA);
        else if (idx == 3'd1) step = mk_step(SK_WR, 1'b0, 1'b0, 12'h2AA, 8'h55);
        else begin
          case (op)
            OP_IDENT: begin
              if (tail == 3'd0)      step = mk_step(SK_WR, 1'b0, 1'b0, 12'h555, 8'h90);
              else if (tail == 3'd1) step = mk_step(SK_RD, 1'b1, 1'b0, 12'h000, 8'h00);
            end
            OP_READ: begin
              if (tail == 3'd0)      step = mk_step(SK_WR, 1'b0, 1'b0, 12'h555, 8'hF0);
              else if (tail == 3'd1) step = mk_step(SK_RD, 1'b1, 1'b0, 12'h000, 8'h00);
            end
            OP_PROG: begin
              if (tail == 3'd0)      step = mk_step(SK_WR, 1'b0, 1'b0, 12'h555, 8'hA0);
              else if (tail == 3'd1) step = mk_step(SK_WR, 1'b1, 1'b1, 12'h000, 8'h00);
            end
            default: begin  // both erase flavours share the first five writes
              if (tail == 3'd0)      step = mk_step(SK_WR, 1'b0, 1'b0, 12'h555, 8'h80);
              else if (tail == 3'd1) step = mk_step(SK_WR, 1'b0, 1'b0, 12'h555, 8'hAA);
              else if (tail == 3'd2) step = mk_step(SK_WR, 1'b0, 1'b0, 12'h2AA, 8'h55);
              else if (tail == 3'd3) begin
                if (op == OP_BERASE) step = mk_step(SK_WR, 1'b1, 1'b0, 12'h000, 8'h30);
                else                 step = mk_step(SK_WR, 1'b0, 1'b0, 12'h555, 8'h10);
              end
            end
          endcase
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/nor_addr_map.sv
module nor_addr_map
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              wide,
  input  step_t             step,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data
);

  localparam int PAD_A = ADDR_W - OFFSET_W - 1;

  logic [ADDR_W-1:0] off_narrow, off_wide;
  logic [DATA_W-1:0] code_ext;

  assign off_narrow = {{(PAD_A + 1){1'b0}}, step.offset};
  assign off_wide   = {{PAD_A{1'b0}}, step.offset, 1'b0};

  generate
    if (DATA_W > CODE_W) begin : g_pad
      assign code_ext = {{(DATA_W - CODE_W){1'b0}}, step.code};
    end else begin : g_exact
      assign code_ext = step.code[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    if (step.host_addr) bus_addr = host_addr;
    else if (wide)      bus_addr = off_wide;
    else                bus_addr = off_narrow;
    bus_data = step.host_data ? host_data : code_ext;
  end

endmodule

// File: rtl/nor_step_timer.sv
module nor_step_timer #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_rd,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_data,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_strobe,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              idle,
  output logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ce_n
);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  function automatic logic [CNT_W-1:0] last_of(logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rd_word <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (go) begin
          phase  <= PH_SETUP;
          cnt    <= last_of(cfg_setup);
          rd_q   <= go_rd;
          addr_q <= go_addr;
          data_q <= go_data;
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_STROBE;
            cnt   <= last_of(cfg_strobe);
          end else cnt <= cnt - 1'b1;
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            phase <= PH_HOLD;
            if (rd_q) rd_word <= mem_rdata;
          end else cnt <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle      = (phase == PH_IDLE);
  assign mem_ce_n  = (phase == PH_IDLE);
  assign mem_we_n  = !((phase == PH_STROBE) && !rd_q);
  assign mem_oe_n  = !((phase == PH_STROBE) && rd_q);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  assert_strobe_inside_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !mem_ce_n);
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  assert_data_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_wdata));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_strobe,
  input  logic              start,
  input  logic [2:0]        opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              reject,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ce_n,
  input  logic [DATA_W-1:0] mem_rdata
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e            state;
  logic [2:0]        op_q;
  logic [2:0]        idx;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  step_t             step;
  logic [ADDR_W-1:0] step_addr;
  logic [DATA_W-1:0] step_data;
  logic              tmr_idle;
  logic              go;

  nor_step_rom u_rom (
    .op   (op_q),
    .idx  (idx),
    .step (step)
  );

  nor_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
    .wide      (cfg_wide),
    .step      (step),
    .host_addr (addr_q),
    .host_data (data_q),
    .bus_addr  (step_addr),
    .bus_data  (step_data)
  );

  assign go = (state == ST_RUN) && tmr_idle && (step.kind != SK_END);

  nor_step_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .go_rd      (step.kind == SK_RD),
    .go_addr    (step_addr),
    .go_data    (step_data),
    .cfg_setup  (cfg_setup),
    .cfg_strobe (cfg_strobe),
    .mem_rdata  (mem_rdata),
    .idle       (tmr_idle),
    .rd_word    (rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_ce_n   (mem_ce_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= '0;
      idx    <= '0;
      addr_q <= '0;
      data_q <= '0;
      done   <= 1'b0;
      error  <= 1'b0;
      reject <= 1'b0;
    end else begin
      done   <= 1'b0;
      error  <= 1'b0;
      reject <= start && (state != ST_IDLE);
      case (state)
        ST_IDLE: if (start) begin
          if (op_is_valid(opcode)) begin
            op_q   <= opcode;
            addr_q <= addr;
            data_q <= wdata;
            idx    <= '0;
            state  <= ST_RUN;
          end else begin
            done  <= 1'b1;
            error <= 1'b1;
          end
        end
        default: if (tmr_idle) begin
          if (step.kind == SK_END) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else idx <= idx + 1'b1;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  assert_reject_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> reject);
  assert_error_has_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
  assert_error_bus_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (mem_ce_n && $past(mem_ce_n)));
  assert_done_ends_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> $past(busy));

endmodule

// File: tb/test_nor_cmd_seq.sv
`timescale 1ns/1ps
module test_nor_cmd_seq;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wide = 1'b1;
  logic [CNT_W-1:0]  cfg_setup = 4'd2;
  logic [CNT_W-1:0]  cfg_strobe = 4'd3;
  logic              start = 1'b0;
  logic [2:0]        opcode = 3'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              busy, done, error, reject;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_we_n, mem_oe_n, mem_ce_n;
  logic [DATA_W-1:0] mem_rdata;

  always #5 clk = ~clk;

  assign mem_rdata = mem_addr[DATA_W-1:0] ^ 16'hC3A5;

  nor_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_setup(cfg_setup),
    .cfg_strobe(cfg_strobe), .start(start), .opcode(opcode), .addr(addr),
    .wdata(wdata), .busy(busy), .done(done), .error(error), .reject(reject),
    .rdata(rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ce_n(mem_ce_n),
    .mem_rdata(mem_rdata)
  );

  typedef struct {
    bit          rd;
    logic [23:0] a;
    logic [15:0] d;
    string       tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  int exp_setup = 2;
  int exp_strobe = 3;
  bit finished = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] cmd_a(logic [11:0] off);
    return cfg_wide ? {11'd0, off, 1'b0} : {12'd0, off};
  endfunction

  function automatic string t(string base);
    return cfg_wide ? base : {base, "/R9"};
  endfunction

  task automatic exp_wr(logic [23:0] a, logic [15:0] d, string tag);
    item_t it;
    it.rd = 0; it.a = a; it.d = d; it.tag = t(tag);
    sbq.push_back(it);
  endtask

  task automatic exp_rd(logic [23:0] a, string tag);
    item_t it;
    it.rd = 1; it.a = a; it.d = '0; it.tag = t(tag);
    sbq.push_back(it);
  endtask

  task automatic push_expect(logic [2:0] op, logic [23:0] a, logic [15:0] d);
    if (op inside {3'd0, 3'd2, 3'd3, 3'd4, 3'd5}) begin
      exp_wr(cmd_a(12'h555), 16'h00AA, "R2");
      exp_wr(cmd_a(12'h2AA), 16'h0055, "R2");
    end
    case (op)
      3'd0: begin exp_wr(cmd_a(12'h555), 16'h0090, "R3"); exp_rd(a, "R3"); end
      3'd1: exp_wr(24'h0, 16'h00F0, "R4");
      3'd2: begin exp_wr(cmd_a(12'h555), 16'h00F0, "R5"); exp_rd(a, "R5"); end
      3'd3: begin exp_wr(cmd_a(12'h555), 16'h00A0, "R6"); exp_wr(a, d, "R6"); end
      3'd4, 3'd5: begin
        exp_wr(cmd_a(12'h555), 16'h0080, "R7");
        exp_wr(cmd_a(12'h555), 16'h00AA, "R7");
        exp_wr(cmd_a(12'h2AA), 16'h0055, "R7");
        if (op == 3'd4) exp_wr(a, 16'h0030, "R7");
        else            exp_wr(cmd_a(12'h555), 16'h0010, "R7");
      end
      3'd6: begin exp_wr(cmd_a(12'h055), 16'h0098, "R8"); exp_rd(a, "R8"); end
      default: ;
    endcase
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic run_cmd(logic [2:0] op, logic [23:0] a, logic [15:0] d);
    push_expect(op, a, d);
    @(negedge clk);
    start = 1; opcode = op; addr = a; wdata = d;
    @(negedge clk);
    start = 0;
    wait_done();
    check((op == 3'd7) ? "R12 done/error" : "R1 done", {30'd0, done, error},
          {30'd0, 1'b1, (op == 3'd7)});
    if (op inside {3'd0, 3'd2, 3'd6})
      check(op == 3'd0 ? "R3 rdata" : (op == 3'd2 ? "R5 rdata" : "R8 rdata"),
            {16'd0, rdata}, {16'd0, a[15:0] ^ 16'hC3A5});
    repeat (3) @(negedge clk);
    check("R11/R12 scoreboard drained", sbq.size(), 0);
  endtask

  // Monitor: pops one expected item per strobe, measures setup and strobe widths.
  int mstate = 0;
  int setup_n = 0;
  int strobe_n = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ce_n) mstate = 0;
      else begin
        if (mstate == 0) begin mstate = 1; setup_n = 0; end
        if (mstate == 1) begin
          if (!mem_we_n || !mem_oe_n) begin
            check("R10 setup width", setup_n, exp_setup);
            mstate = 2; strobe_n = 1;
            if (sbq.size() == 0) begin
              checks++; errors++;
              $display("FAIL R11/R12: unexpected bus cycle at %h, actual 1 expected 0", mem_addr);
            end else begin
              item_t it;
              it = sbq.pop_front();
              check({it.tag, " kind"}, {31'd0, !mem_oe_n}, {31'd0, it.rd});
              check({it.tag, " addr"}, {8'd0, mem_addr}, {8'd0, it.a});
              if (!it.rd) check({it.tag, " data"}, {16'd0, mem_wdata}, {16'd0, it.d});
            end
          end else setup_n++;
        end else if (mstate == 2) begin
          if (!mem_we_n || !mem_oe_n) strobe_n++;
          else begin
            check("R10 strobe width", strobe_n, exp_strobe);
            mstate = 3;
          end
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset bus", {29'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'd7);
    check("R1 reset flags", {28'd0, busy, done, error, reject}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {28'd0, busy, done, error, reject}, 32'd0);

    // 16-bit device, setup 2, strobe 3
    cfg_wide = 1; cfg_setup = 4'd2; cfg_strobe = 4'd3; exp_setup = 2; exp_strobe = 3;
    run_cmd(3'd0, 24'h000000, 16'h0);
    run_cmd(3'd1, 24'h000000, 16'h0);
    run_cmd(3'd2, 24'h01F2A4, 16'h0);
    run_cmd(3'd3, 24'h004466, 16'hBEEF);
    run_cmd(3'd4, 24'h120000, 16'h0);
    run_cmd(3'd5, 24'h000000, 16'h0);
    run_cmd(3'd6, 24'h000020, 16'h0);
    run_cmd(3'd7, 24'h000555, 16'h0);

    // 8-bit device, zero counts act as one
    cfg_wide = 0; cfg_setup = 4'd0; cfg_strobe = 4'd0; exp_setup = 1; exp_strobe = 1;
    run_cmd(3'd0, 24'h000001, 16'h0);
    run_cmd(3'd3, 24'h00ABCD, 16'h1234);
    run_cmd(3'd4, 24'h340000, 16'h0);
    run_cmd(3'd6, 24'h000010, 16'h0);
    run_cmd(3'd1, 24'h000000, 16'h0);

    // asymmetric timing, 16-bit
    cfg_wide = 1; cfg_setup = 4'd5; cfg_strobe = 4'd1; exp_setup = 5; exp_strobe = 1;
    run_cmd(3'd5, 24'h0, 16'h0);
    run_cmd(3'd2, 24'h00FFFE, 16'h0);

    // R11: refused request during a program command
    push_expect(3'd3, 24'h007700, 16'hA5A5);
    @(negedge clk);
    start = 1; opcode = 3'd3; addr = 24'h007700; wdata = 16'hA5A5;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    check("R11 busy in flight", {31'd0, busy}, 32'd1);
    start = 1; opcode = 3'd1; addr = 24'h0; wdata = 16'h0;
    @(negedge clk);
    start = 0;
    check("R11 reject pulse", {31'd0, reject}, 32'd1);
    @(negedge clk);
    check("R11 reject one cycle", {31'd0, reject}, 32'd0);
    wait_done();
    check("R11 done no error", {30'd0, done, error}, 32'd2);
    repeat (3) @(negedge clk);
    check("R11 scoreboard drained", sbq.size(), 0);

    // R12 invalid opcode in 8-bit mode
    cfg_wide = 0;
    run_cmd(3'd7, 24'h0, 16'h0);
    repeat (5) @(negedge clk);
    summary();
  end

endmodule